// File: doc/BRIEF.md
# GPIO Bank with Masked Writes and Per-Pin Interrupt Detection

This block is one bank of 32 general-purpose pins, grouped as four ports of eight pins, controlled through a plain 32-bit register bus with a single-cycle write strobe and a combinational read path. For every port, software sets a GPIO-mode enable, a drive enable and a drive value, reads the synchronized pad level, and configures, enables and acknowledges a per-pin interrupt. The bank combines all enabled, pending pins into one interrupt output.

Each writable register group can also be reached through an alias placed at a parameterized offset above the base map. A write through the alias touches only the pins whose enable bit (bit n+8) is set, which lets several agents own different pins of a port without read-modify-write races. Interrupt detection works on a two-flop synchronized copy of each pad and supports rising, falling and both-edge triggers as well as active-high and active-low levels.

Top module: `gpio_bank32`

## Requirements
- R1: After reset, the mode-enable, drive-enable, drive-value, interrupt-enable and interrupt-type registers of every port read 0, `pad_oe` is 0 and `irq` is 0.
- R2: Register group g of port p sits at byte address g*0x10 + p*4 with groups 0 mode enable, 1 drive enable, 2 drive value, 3 pad input, 4 status, 5 interrupt enable, 6 interrupt type, 7 clear; a plain write stores bits 7:0 (bits 23:0 for the type group) and reads return the register in the low bits with the rest 0.
- R3: At address `MASK_OFS` + g*0x10 + p*4 (groups 0, 1, 2, 4, 5, 6) a write updates pin n only when data bit n+8 is 1, taking the new value from bit n; for the type group only the polarity plane (bits 7:0) is updated. Plain writes to the input and status groups have no effect.
- R4: `pad_out` carries the drive-value register and `pad_oe` bit k is 1 exactly when the mode-enable and drive-enable bits of pin k are both 1.
- R5: The input group returns the pad level through a two-flop synchronizer: a pad change made before a clock edge is visible on reads after the second edge, not after the first.
- R6: Type bits n, n+8, n+16 of a port select pin n's trigger: 0x000101 rising, 0x000100 falling, 0x010100 both edges (pattern shifted left by n); an edge sets status at the third clock edge after the pad change, and status then stays set until cleared.
- R7: Type pattern 0x000001 selects active-high and 0x000000 active-low level detection; while the active level is present the status bit cannot be cleared.
- R8: Writing 1 to bit n of the clear group clears status of pin n; 0 bits leave status unchanged; the clear group reads 0.
- R9: When a detection and a clear hit the same pin in the same cycle, the status bit ends up set.
- R10: `irq` is 1 exactly when some pin in any port has both its status and interrupt-enable bits set.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| bus_wr | input | 1 | Write strobe, one write per cycle |
| bus_addr | input | ADDR_W | Byte address |
| bus_wdata | input | 32 | Write data |
| bus_rdata | output | 32 | Read data for `bus_addr`, combinational |
| pad_in | input | 32 | Pad levels, asynchronous |
| pad_out | output | 32 | Drive values |
| pad_oe | output | 32 | Per-pin drive enable, 0 means tri-stated |
| irq | output | 1 | Combined bank interrupt |

## Verification
On every cycle the checker confirms that a status bit only rises after a detection or a masked status write, only falls after a clear or masked status write, that edge-mode status holds on its own, that a detection always leaves status set even against a clear, and that the interrupt and drive-enable outputs never appear without their enabling configuration. The exact three-edge detection latency, the trigger encodings, the register map and aliasing, and the behaviour of level pins under clear are only shown by the bench's directed scenarios and its randomized write/readback model.

// File: rtl/gpio_bank32.sv
module gpio_bank32 #(
  parameter int ADDR_W   = 8,
  parameter int MASK_OFS = 128
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              bus_wr,
  input  logic [ADDR_W-1:0] bus_addr,
  input  logic [31:0]       bus_wdata,
  output logic [31:0]       bus_rdata,
  input  logic [31:0]       pad_in,
  output logic [31:0]       pad_out,
  output logic [31:0]       pad_oe,
  output logic              irq
);
  localparam logic [ADDR_W-1:0] MOFS  = ADDR_W'(MASK_OFS);
  localparam logic [ADDR_W-1:0] SPAN  = ADDR_W'(128);

  logic [31:0] cnf, oe, outv, enb, sta, pol, edg, both;
  logic [31:0] s1, s, prv;
  logic [31:0] det, clr_bits, stw_bits, stw_val, sta_n;

  logic              masked, hit;
  logic [ADDR_W-1:0] off;
  logic [2:0]        grp;
  logic [1:0]        port;
  logic [4:0]        base;

  assign masked = bus_addr >= MOFS;
  assign off    = masked ? bus_addr - MOFS : bus_addr;
  assign grp    = off[6:4];
  assign port   = off[3:2];
  assign base   = {port, 3'b000};
  assign hit    = bus_wr && (off < SPAN);

  logic unused_ok;
  assign unused_ok = ^{bus_wdata[31:24], off[1:0]};

  function automatic logic [7:0] merge8(input logic [7:0] old, input logic [31:0] wd, input logic msk);
    return msk ? ((old & ~wd[15:8]) | (wd[7:0] & wd[15:8])) : wd[7:0];
  endfunction

  // detection on the synchronized copy
  logic [31:0] rise, fall, edge_hit, lvl_hit;
  assign rise     = s & ~prv;
  assign fall     = ~s & prv;
  assign edge_hit = (both & (rise | fall)) | (~both & ((pol & rise) | (~pol & fall)));
  assign lvl_hit  = ~(pol ^ s);
  assign det      = (edg & edge_hit) | (~edg & lvl_hit);

  assign clr_bits = (hit && !masked && grp == 3'd7) ? ({24'b0, bus_wdata[7:0]} << base) : 32'b0;
  assign stw_bits = (hit && masked && grp == 3'd4) ? ({24'b0, bus_wdata[15:8]} << base) : 32'b0;
  assign stw_val  = {24'b0, bus_wdata[7:0]} << base;
  assign sta_n    = ((((sta & ~stw_bits) | (stw_val & stw_bits)) & ~clr_bits)) | det;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      cnf <= '0; oe <= '0; outv <= '0; enb <= '0; sta <= '0;
      pol <= '0; edg <= '0; both <= '0;
      s1 <= '0; s <= '0; prv <= '0;
    end else begin
      s1  <= pad_in;
      s   <= s1;
      prv <= s;
      sta <= sta_n;
      if (hit) begin
        case (grp)
          3'd0: cnf[base +: 8]  <= merge8(cnf[base +: 8], bus_wdata, masked);
          3'd1: oe[base +: 8]   <= merge8(oe[base +: 8], bus_wdata, masked);
          3'd2: outv[base +: 8] <= merge8(outv[base +: 8], bus_wdata, masked);
          3'd5: enb[base +: 8]  <= merge8(enb[base +: 8], bus_wdata, masked);
          3'd6: begin
            if (masked) pol[base +: 8] <= merge8(pol[base +: 8], bus_wdata, 1'b1);
            else {both[base +: 8], edg[base +: 8], pol[base +: 8]} <= bus_wdata[23:0];
          end
          default: ;
        endcase
      end
    end
  end

  always_comb begin
    case (grp)
      3'd0:    bus_rdata = {24'b0, cnf[base +: 8]};
      3'd1:    bus_rdata = {24'b0, oe[base +: 8]};
      3'd2:    bus_rdata = {24'b0, outv[base +: 8]};
      3'd3:    bus_rdata = {24'b0, s[base +: 8]};
      3'd4:    bus_rdata = {24'b0, sta[base +: 8]};
      3'd5:    bus_rdata = {24'b0, enb[base +: 8]};
      3'd6:    bus_rdata = {8'b0, both[base +: 8], edg[base +: 8], pol[base +: 8]};
      default: bus_rdata = 32'b0;
    endcase
    if (off >= SPAN) bus_rdata = 32'b0;
  end

  assign pad_out = outv;
  assign pad_oe  = cnf & oe;
  assign irq     = |(sta & enb);
endmodule

module gpio_bank32_chk (
  input logic        clk,
  input logic        rst_n,
  input logic        irq,
  input logic [31:0] sta,
  input logic [31:0] enb,
  input logic [31:0] cnf,
  input logic [31:0] pad_oe,
  input logic [31:0] edg,
  input logic [31:0] det,
  input logic [31:0] clr_bits,
  input logic [31:0] stw_bits
);
  assert_irq_needs_enable_R10: assert property (@(posedge clk) disable iff (!rst_n)
    irq |-> (enb != 32'b0));

  assert_drive_needs_mode_R4: assert property (@(posedge clk) disable iff (!rst_n)
    (pad_oe & ~cnf) == 32'b0);

  assert_edge_holds_R6: assert property (@(posedge clk) disable iff (!rst_n)
    1'b1 |=> ((($past(sta) & $past(edg) & ~$past(clr_bits) & ~$past(stw_bits)) & ~sta) == 32'b0));

  assert_set_has_cause_R3: assert property (@(posedge clk) disable iff (!rst_n)
    1'b1 |=> (((sta & ~$past(sta)) & ~$past(det) & ~$past(stw_bits)) == 32'b0));

  assert_drop_has_cause_R8: assert property (@(posedge clk) disable iff (!rst_n)
    1'b1 |=> ((($past(sta) & ~sta) & ~$past(clr_bits) & ~$past(stw_bits)) == 32'b0));

  assert_detect_wins_R9: assert property (@(posedge clk) disable iff (!rst_n)
    1'b1 |=> (($past(det) & ~sta) == 32'b0));
endmodule

bind gpio_bank32 gpio_bank32_chk u_chk (
  .clk(clk), .rst_n(rst_n), .irq(irq), .sta(sta), .enb(enb), .cnf(cnf),
  .pad_oe(pad_oe), .edg(edg), .det(det), .clr_bits(clr_bits), .stw_bits(stw_bits)
);

// File: tb/gpio_bank32_tb.sv
module gpio_bank32_tb;
  logic        clk = 0, rst_n = 0, bus_wr = 0;
  logic [7:0]  bus_addr = 0;
  logic [31:0] bus_wdata = 0, bus_rdata, pad_in = 0, pad_out, pad_oe;
  logic        irq;
  int n_chk = 0, n_fail = 0;

  always #10 clk = ~clk;

  gpio_bank32 u_dut (.clk(clk), .rst_n(rst_n), .bus_wr(bus_wr), .bus_addr(bus_addr),
    .bus_wdata(bus_wdata), .bus_rdata(bus_rdata), .pad_in(pad_in), .pad_out(pad_out),
    .pad_oe(pad_oe), .irq(irq));

  logic [31:0] m_cnf = 0, m_oe = 0, m_out = 0, m_enb = 0, m_pol = 0, m_edg = 0, m_both = 0;

  task automatic chk(input string tag, input logic [31:0] got, input logic [31:0] exp);
    n_chk++;
    if (got !== exp) begin
      n_fail++;
      $display("FAIL %s: got %h expected %h", tag, got, exp);
    end
  endtask

  task automatic wr(input logic [7:0] a, input logic [31:0] d);
    @(negedge clk); bus_addr = a; bus_wdata = d; bus_wr = 1;
    @(negedge clk); bus_wr = 0;
  endtask

  task automatic rd(input logic [7:0] a, output logic [31:0] d);
    @(negedge clk); bus_addr = a; #1; d = bus_rdata;
  endtask

  task automatic waitc(input int n);
    repeat (n) @(negedge clk);
  endtask

  function automatic logic [7:0] merge(input logic [7:0] old, input logic [31:0] d, input logic m);
    return m ? ((old & ~d[15:8]) | (d[7:0] & d[15:8])) : d[7:0];
  endfunction

  function automatic logic [31:0] exp_rd(input int g, input int p);
    case (g)
      0: return {24'b0, m_cnf[p*8 +: 8]};
      1: return {24'b0, m_oe[p*8 +: 8]};
      2: return {24'b0, m_out[p*8 +: 8]};
      5: return {24'b0, m_enb[p*8 +: 8]};
      default: return {8'b0, m_both[p*8 +: 8], m_edg[p*8 +: 8], m_pol[p*8 +: 8]};
    endcase
  endfunction

  initial begin
    #(20 * 150000);
    n_chk++; n_fail++;
    $display("FAIL watchdog: got timeout expected completion");
    $display("%0d/%0d checks passed", n_chk - n_fail, n_chk);
    $finish;
  end

  initial begin
    logic [31:0] r;
    int grps[5] = '{0, 1, 2, 5, 6};
    void'($urandom(32'd4711));
    #35 rst_n = 1;
    waitc(2);

    // R1 reset state
    for (int p = 0; p < 4; p++)
      for (int gi = 0; gi < 5; gi++) begin
        rd(8'(grps[gi] * 16 + p * 4), r);
        chk("R1 reset register", r, 32'h0);
      end
    chk("R1 pad_oe", pad_oe, 0);
    chk("R1 irq", {31'b0, irq}, 0);

    // R2 plain write stores low byte only
    wr(8'h28, 32'h12345678);
    m_out[23:16] = 8'h78;
    rd(8'h28, r); chk("R2 plain write low byte", r, 32'h78);

    // R3 masked alias
    wr(8'h28, 32'hA5);
    wr(8'hA8, 32'h0FFF);
    m_out[23:16] = 8'hAF;
    rd(8'h28, r); chk("R3 masked write merge", r, 32'hAF);
    chk("R4 pad_out", pad_out, m_out);

    // R5 synchronizer latency
    @(negedge clk); pad_in = 32'hDEADBEEF;
    bus_addr = 8'h38;
    @(negedge clk); #1; chk("R5 input after one edge", bus_rdata, 32'h00);
    @(negedge clk); #1; chk("R5 input after two edges", bus_rdata, 32'hAD);
    wr(8'h38, 32'hFF);
    rd(8'h38, r); chk("R3 plain input write ignored", r, 32'hAD);
    @(negedge clk); pad_in = 0;
    waitc(3);

    // R2 R3 R4 randomized map/alias/pad model
    for (int i = 0; i < 300; i++) begin
      int g, p; logic m; logic [31:0] d;
      g = grps[$urandom % 5]; p = $urandom % 4; m = $urandom % 2; d = $urandom;
      case (g)
        0: m_cnf[p*8 +: 8] = merge(m_cnf[p*8 +: 8], d, m);
        1: m_oe[p*8 +: 8]  = merge(m_oe[p*8 +: 8], d, m);
        2: m_out[p*8 +: 8] = merge(m_out[p*8 +: 8], d, m);
        5: m_enb[p*8 +: 8] = merge(m_enb[p*8 +: 8], d, m);
        default: if (m) m_pol[p*8 +: 8] = merge(m_pol[p*8 +: 8], d, 1'b1);
                 else {m_both[p*8 +: 8], m_edg[p*8 +: 8], m_pol[p*8 +: 8]} = d[23:0];
      endcase
      wr(8'((m ? 128 : 0) + g * 16 + p * 4), d);
      rd(8'(g * 16 + p * 4), r);
      chk(m ? "R3 random masked readback" : "R2 random plain readback", r, exp_rd(g, p));
      chk("R4 random pad_oe", pad_oe, m_cnf & m_oe);
      chk("R4 random pad_out", pad_out, m_out);
    end

    // quiet state: all interrupts disabled, all level-low
    for (int p = 0; p < 4; p++) begin
      wr(8'(8'h50 + p * 4), 0);
      wr(8'(8'h60 + p * 4), 0);
    end
    rd(8'h74, r); chk("R8 clear group reads zero", r, 0);

    // R6 rising edge on pin 11 (port 1, pin 3)
    wr(8'h64, 32'h000808);
    waitc(3);
    wr(8'h74, 32'hFF);
    wr(8'hD4, 32'h0808);
    chk("R6 rising idle irq", {31'b0, irq}, 0);
    @(negedge clk); pad_in[11] = 1;
    waitc(2); chk("R6 latency two edges", {31'b0, irq}, 0);
    waitc(1); chk("R6 latency three edges", {31'b0, irq}, 1);
    pad_in[11] = 0; waitc(4);
    chk("R6 edge status holds", {31'b0, irq}, 1);
    rd(8'h44, r); chk("R6 status bit", r & 32'h08, 32'h08);
    wr(8'h74, 32'h00);
    chk("R8 zero clear no effect", {31'b0, irq}, 1);
    wr(8'h74, 32'h08);
    chk("R8 clear drops irq", {31'b0, irq}, 0);

    // R6 falling
    wr(8'h64, 32'h000800);
    @(negedge clk); pad_in[11] = 1; waitc(4);
    wr(8'h74, 32'h08);
    chk("R6 falling ignores rise", {31'b0, irq}, 0);
    pad_in[11] = 0; waitc(4);
    chk("R6 falling detects", {31'b0, irq}, 1);

    // R6 both edges
    wr(8'h64, 32'h080800);
    wr(8'h74, 32'h08);
    chk("R6 both idle", {31'b0, irq}, 0);
    pad_in[11] = 1; waitc(4);
    chk("R6 both rise", {31'b0, irq}, 1);
    wr(8'h74, 32'h08);
    pad_in[11] = 0; waitc(4);
    chk("R6 both fall", {31'b0, irq}, 1);

    // R7 level high
    wr(8'h64, 32'h000008);
    wr(8'h74, 32'h08);
    chk("R7 high inactive", {31'b0, irq}, 0);
    pad_in[11] = 1; waitc(4);
    chk("R7 high active", {31'b0, irq}, 1);
    wr(8'h74, 32'h08);
    chk("R7 high clear while active", {31'b0, irq}, 1);
    pad_in[11] = 0; waitc(4);
    wr(8'h74, 32'h08);
    chk("R7 high clear after release", {31'b0, irq}, 0);

    // R7 level low
    wr(8'h64, 32'h000000);
    waitc(1);
    chk("R7 low active", {31'b0, irq}, 1);
    wr(8'h74, 32'h08);
    chk("R7 low clear while active", {31'b0, irq}, 1);
    pad_in[11] = 1; waitc(4);
    wr(8'h74, 32'h08);
    chk("R7 low clear after release", {31'b0, irq}, 0);

    // R9 detection and clear in the same cycle
    wr(8'h64, 32'h000808);
    pad_in[11] = 0; waitc(4);
    wr(8'h74, 32'h08);
    chk("R9 setup", {31'b0, irq}, 0);
    pad_in[11] = 1;
    waitc(2);
    bus_addr = 8'h74; bus_wdata = 32'h08; bus_wr = 1;
    @(negedge clk); bus_wr = 0;
    chk("R9 detect beats clear", {31'b0, irq}, 1);
    wr(8'h74, 32'h08);
    chk("R9 later clear", {31'b0, irq}, 0);

    // R10 enable gating and OR across ports
    wr(8'h64, 32'h000000); pad_in[11] = 0; waitc(3);
    chk("R10 enabled pending", {31'b0, irq}, 1);
    wr(8'hD4, 32'h0800);
    chk("R10 disabled pending", {31'b0, irq}, 0);

    // R3 masked status write on port 3 (rising mode)
    wr(8'h6C, 32'h00FFFF);
    waitc(3);
    wr(8'h7C, 32'hFF);
    rd(8'h4C, r); chk("R3 status cleared", r, 0);
    wr(8'h4C, 32'hFF);
    rd(8'h4C, r); chk("R3 plain status write ignored", r, 0);
    wr(8'hCC, 32'h4040);
    rd(8'h4C, r); chk("R3 masked status set", r, 32'h40);
    wr(8'hDC, 32'h4040);
    chk("R10 irq from port 3", {31'b0, irq}, 1);
    wr(8'hCC, 32'h4000);
    rd(8'h4C, r); chk("R3 masked status clear", r, 0);
    chk("R10 irq gone", {31'b0, irq}, 0);

    $display("%0d/%0d checks passed", n_chk - n_fail, n_chk);
    $finish;
  end
endmodule